// File: doc/BRIEF.md
# Indirect Memory-Controller Configuration Register File

This block holds the configuration and status registers of a DDR memory controller. A host reaches them through a pair of ports on a narrow register bus. Writing the select port stores a 32-bit register offset. Later accesses to the data port read or write whichever register that offset names. The register set covers these areas:

- two error-status words and an error-address word;
- a configuration word and a status word that follows it;
- refresh, power-management and timing words;
- ECC configuration and ECC error words;
- four bank words.

Many registers alter what is written: they mask fields, force bits on or clear on a written one. Two events in the configuration word are copied into the status word: the global enable being switched, and bit 30 being switched. The block drives a global memory-enable output. It also drives an interrupt that is raised while the ECC error word is nonzero. Two error-set inputs let the surrounding controller post error flags into the two error-status words.

The bus has single-cycle read and write strobes. Read data is registered and comes back one cycle after the strobe. Every register access therefore costs one clock of latency and needs no handshake.

Top module: `memctl_cfg_regs`

## Requirements
- R1: A write to port number 0x10 stores the full 32-bit write value as the register offset. A read of port 0x10 returns that stored offset.
- R2: `rdata` and `rvalid` update in the clock edge that follows an `rd_en` cycle. `rdata` holds its value when no read takes place. Writes to any port number other than 0x10 or 0x11 change nothing. Reads of those port numbers return 0.
- R3: After reset the registers read as follows: offset register 0, configuration 0x00800000, refresh 0x05F00000, power-management 0x07C00000. Every other stored register reads 0. `irq` is 0 and `mem_enable` is 0.
- R4: The error-status words at offsets 0x00 and 0x08 clear each bit written as one. `err_set_a` feeds offset 0x00 and `err_set_b` feeds offset 0x08, and a set pulse on either input ORs its bits in. When a set and a clear hit the same bit in the same cycle, the set wins.
- R5: The error-address word at offset 0x10 stores and returns the full write value.
- R6: A write to the configuration word at offset 0x20 keeps only bits 31:21.
- R7: `mem_enable` equals configuration bit 31. When bit 31 goes from 0 to 1, status bit 31 is cleared. When it goes from 1 to 0, status bit 31 is set.
- R8: When configuration bit 30 goes from 0 to 1, status bit 30 is set. When it goes from 1 to 0, status bit 30 is cleared. Writes to the status word at offset 0x24 have no effect.
- R9: The refresh word at offset 0x30 stores the write ANDed with 0x3FF80000. The power-management word at offset 0x34 stores write bits 31:27 ORed with 0x07C00000.
- R10: The bank words at offsets 0x40, 0x44, 0x48 and 0x4C are independent. Each stores its write ANDed with 0xFFDEE001.
- R11: The timing word at offset 0x80 always reads 0xFFFFFFFF. Any offset that names no register also reads 0xFFFFFFFF.
- R12: The ECC configuration word at offset 0x94 stores the write ANDed with 0x00F00000. The ECC error word at offset 0x98 stores the write ANDed with 0xFFF0F000.
- R13: `irq` rises when a write takes the ECC error word from zero to nonzero. It falls when a write returns the word to zero. A write whose bits are all masked away counts as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| port_num | input | 10 | Port number of the access (0x10 select, 0x11 data) |
| wdata | input | 32 | Write data |
| err_set_a | input | 32 | Bits to set in the error-status word at offset 0x00 |
| err_set_b | input | 32 | Bits to set in the error-status word at offset 0x08 |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | High for one cycle when `rdata` carries a read result |
| irq | output | 1 | ECC error interrupt |
| mem_enable | output | 1 | Global memory enable (configuration bit 31) |

## Verification
Every masked register is written with all ones and then with a distinct pattern. The all-ones write shows which field mask is applied. The distinct pattern tells the four bank words apart and shows that an address decode error does not alias one word onto another. The configuration word is driven through both enable rise and fall, with bit 30 switched together with bit 31. This separates an edge-triggered status update from a simple copy of the configuration bits. The ECC error word is written with a value that masks to zero, then a nonzero value, then zero again. This shows the interrupt follows the stored value and not the raw write. The error-set inputs are pulsed both alone and together with a one-to-clear write on the same bit, which settles the priority between set and clear.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;
  localparam int DW = 32;

  localparam logic [DW-1:0] OFS_ERRST_A = 32'h0000_0000;
  localparam logic [DW-1:0] OFS_ERRST_B = 32'h0000_0008;
  localparam logic [DW-1:0] OFS_ERRADR  = 32'h0000_0010;
  localparam logic [DW-1:0] OFS_CONFIG  = 32'h0000_0020;
  localparam logic [DW-1:0] OFS_STATUS  = 32'h0000_0024;
  localparam logic [DW-1:0] OFS_REFRESH = 32'h0000_0030;
  localparam logic [DW-1:0] OFS_PWRMGT  = 32'h0000_0034;
  localparam logic [DW-1:0] OFS_BANK0   = 32'h0000_0040;
  localparam logic [DW-1:0] OFS_TIMING  = 32'h0000_0080;
  localparam logic [DW-1:0] OFS_ECCCFG  = 32'h0000_0094;
  localparam logic [DW-1:0] OFS_ECCERR  = 32'h0000_0098;

  localparam logic [DW-1:0] MSK_CONFIG  = 32'hFFE0_0000;
  localparam logic [DW-1:0] MSK_REFRESH = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_PWRMGT  = 32'hF800_0000;
  localparam logic [DW-1:0] FRC_PWRMGT  = 32'h07C0_0000;
  localparam logic [DW-1:0] MSK_BANK    = 32'hFFDE_E001;
  localparam logic [DW-1:0] MSK_ECCCFG  = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_ECCERR  = 32'hFFF0_F000;

  localparam logic [DW-1:0] RST_CONFIG  = 32'h0080_0000;
  localparam logic [DW-1:0] RST_REFRESH = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PWRMGT  = FRC_PWRMGT;

  localparam int BIT_ENABLE = 31;
  localparam int BIT_AUX    = 30;

  localparam logic [DW-1:0] ALL_ONES = '1;
endpackage

// File: rtl/memctl_port_dec.sv
module memctl_port_dec #(
  parameter int PORT_W    = 10,
  parameter int SEL_PORT  = 16,
  parameter int DATA_PORT = 17
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [PORT_W-1:0]                port_num,
  input  logic [memctl_cfg_pkg::DW-1:0]    wdata,
  output logic [memctl_cfg_pkg::DW-1:0]    offset_q,
  output logic                             data_wr,
  output logic                             data_rd,
  output logic                             sel_rd
);
  import memctl_cfg_pkg::*;

  localparam logic [PORT_W-1:0] SEL_P  = PORT_W'(SEL_PORT);
  localparam logic [PORT_W-1:0] DATA_P = PORT_W'(DATA_PORT);

  logic hit_sel, hit_data;

  assign hit_sel  = (port_num == SEL_P);
  assign hit_data = (port_num == DATA_P);
  assign data_wr  = wr_en & hit_data;
  assign data_rd  = rd_en & hit_data;
  assign sel_rd   = rd_en & hit_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) offset_q <= '0;
    else if (wr_en && hit_sel) offset_q <= wdata;
  end
endmodule

// File: rtl/memctl_reg_core.sv
module memctl_reg_core #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_STEP = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          data_wr,
  input  logic [memctl_cfg_pkg::DW-1:0] offset,
  input  logic [memctl_cfg_pkg::DW-1:0] wdata,
  input  logic [memctl_cfg_pkg::DW-1:0] set_a,
  input  logic [memctl_cfg_pkg::DW-1:0] set_b,
  output logic [memctl_cfg_pkg::DW-1:0] rd_word,
  output logic                          irq_q,
  output logic                          enable
);
  import memctl_cfg_pkg::*;

  logic [DW-1:0] errst_a, errst_b, erradr, config_q, status_q;
  logic [DW-1:0] refresh_q, pwrmgt_q, ecccfg_q, eccerr_q;
  logic [DW-1:0] bank_q [NUM_BANKS];

  logic wr_errst_a, wr_errst_b, wr_erradr, wr_config;
  logic wr_refresh, wr_pwrmgt, wr_ecccfg, wr_eccerr;
  logic [DW-1:0] cfg_new, eccerr_new;
  logic en_rise, en_fall, aux_rise, aux_fall;

  assign wr_errst_a = data_wr && (offset == OFS_ERRST_A);
  assign wr_errst_b = data_wr && (offset == OFS_ERRST_B);
  assign wr_erradr  = data_wr && (offset == OFS_ERRADR);
  assign wr_config  = data_wr && (offset == OFS_CONFIG);
  assign wr_refresh = data_wr && (offset == OFS_REFRESH);
  assign wr_pwrmgt  = data_wr && (offset == OFS_PWRMGT);
  assign wr_ecccfg  = data_wr && (offset == OFS_ECCCFG);
  assign wr_eccerr  = data_wr && (offset == OFS_ECCERR);

  assign cfg_new    = wdata & MSK_CONFIG;
  assign eccerr_new = wdata & MSK_ECCERR;
  assign en_rise  = wr_config && !config_q[BIT_ENABLE] &&  cfg_new[BIT_ENABLE];
  assign en_fall  = wr_config &&  config_q[BIT_ENABLE] && !cfg_new[BIT_ENABLE];
  assign aux_rise = wr_config && !config_q[BIT_AUX]    &&  cfg_new[BIT_AUX];
  assign aux_fall = wr_config &&  config_q[BIT_AUX]    && !cfg_new[BIT_AUX];

  // Error status: one-to-clear by the host, set pulses from the controller win.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errst_a <= '0;
      errst_b <= '0;
    end else begin
      errst_a <= (errst_a & ~(wr_errst_a ? wdata : '0)) | set_a;
      errst_b <= (errst_b & ~(wr_errst_b ? wdata : '0)) | set_b;
    end
  end

  // Plain, masked and forced-bit registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erradr    <= '0;
      config_q  <= RST_CONFIG;
      refresh_q <= RST_REFRESH;
      pwrmgt_q  <= RST_PWRMGT;
      ecccfg_q  <= '0;
    end else begin
      if (wr_erradr)  erradr    <= wdata;
      if (wr_config)  config_q  <= cfg_new;
      if (wr_refresh) refresh_q <= wdata & MSK_REFRESH;
      if (wr_pwrmgt)  pwrmgt_q  <= (wdata & MSK_PWRMGT) | FRC_PWRMGT;
      if (wr_ecccfg)  ecccfg_q  <= wdata & MSK_ECCCFG;
    end
  end

  // Status mirrors configuration edges; host writes never reach it.
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else begin
      if (en_rise)       status_q[BIT_ENABLE] <= 1'b0;
      else if (en_fall)  status_q[BIT_ENABLE] <= 1'b1;
      if (aux_rise)      status_q[BIT_AUX]    <= 1'b1;
      else if (aux_fall) status_q[BIT_AUX]    <= 1'b0;
    end
  end

  // ECC error word and its interrupt, updated together.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eccerr_q <= '0;
      irq_q    <= 1'b0;
    end else if (wr_eccerr) begin
      eccerr_q <= eccerr_new;
      if (eccerr_q == '0 && eccerr_new != '0)      irq_q <= 1'b1;
      else if (eccerr_q != '0 && eccerr_new == '0) irq_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [DW-1:0] BOFS = OFS_BANK0 + DW'(b * BANK_STEP);
    always_ff @(posedge clk) begin
      if (!rst_n) bank_q[b] <= '0;
      else if (data_wr && offset == BOFS) bank_q[b] <= wdata & MSK_BANK;
    end
  end

  assign enable = config_q[BIT_ENABLE];

  always_comb begin
    rd_word = ALL_ONES;
    unique case (offset)
      OFS_ERRST_A: rd_word = errst_a;
      OFS_ERRST_B: rd_word = errst_b;
      OFS_ERRADR:  rd_word = erradr;
      OFS_CONFIG:  rd_word = config_q;
      OFS_STATUS:  rd_word = status_q;
      OFS_REFRESH: rd_word = refresh_q;
      OFS_PWRMGT:  rd_word = pwrmgt_q;
      OFS_TIMING:  rd_word = ALL_ONES;
      OFS_ECCCFG:  rd_word = ecccfg_q;
      OFS_ECCERR:  rd_word = eccerr_q;
      default:     rd_word = ALL_ONES;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (offset == OFS_BANK0 + DW'(b * BANK_STEP)) rd_word = bank_q[b];
    end
  end
endmodule

// File: rtl/memctl_rd_stage.sv
module memctl_rd_stage (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic                          sel_rd,
  input  logic                          data_rd,
  input  logic [memctl_cfg_pkg::DW-1:0] offset,
  input  logic [memctl_cfg_pkg::DW-1:0] reg_word,
  output logic [memctl_cfg_pkg::DW-1:0] rdata,
  output logic                          rvalid
);
  import memctl_cfg_pkg::*;

  logic [DW-1:0] rd_next;

  always_comb begin
    if (sel_rd)       rd_next = offset;
    else if (data_rd) rd_next = reg_word;
    else              rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs #(
  parameter int PORT_W    = 10,
  parameter int SEL_PORT  = 16,
  parameter int DATA_PORT = 17,
  parameter int NUM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [PORT_W-1:0] port_num,
  input  logic [31:0]       wdata,
  input  logic [31:0]       err_set_a,
  input  logic [31:0]       err_set_b,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              irq,
  output logic              mem_enable
);
  import memctl_cfg_pkg::*;

  logic [DW-1:0] offset_q, reg_word;
  logic data_wr, data_rd, sel_rd;

  memctl_port_dec #(
    .PORT_W(PORT_W), .SEL_PORT(SEL_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_num(port_num), .wdata(wdata), .offset_q(offset_q),
    .data_wr(data_wr), .data_rd(data_rd), .sel_rd(sel_rd)
  );

  memctl_reg_core #(.NUM_BANKS(NUM_BANKS), .BANK_STEP(4)) u_core (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .offset(offset_q),
    .wdata(wdata), .set_a(err_set_a), .set_b(err_set_b),
    .rd_word(reg_word), .irq_q(irq), .enable(mem_enable)
  );

  memctl_rd_stage u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel_rd(sel_rd),
    .data_rd(data_rd), .offset(offset_q), .reg_word(reg_word),
    .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/memctl_cfg_chk.sv
module memctl_cfg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] rdata,
  input logic        rvalid,
  input logic        irq,
  input logic        mem_enable
);
  // R2
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid == $past(rd_en));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));

  // R7
  enable_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(mem_enable));

  // R13
  irq_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(irq));

  // R13
  irq_rise_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en));
endmodule

bind memctl_cfg_regs memctl_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .rvalid(rvalid), .irq(irq), .mem_enable(mem_enable)
);

// File: tb/memctl_cfg_regs_test.sv
module memctl_cfg_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  port_num = '0;
  logic [31:0] wdata = '0, err_set_a = '0, err_set_b = '0;
  logic [31:0] rdata;
  logic rvalid, irq, mem_enable;
  int checks = 0, fails = 0;
  logic [31:0] got;

  localparam logic [9:0] PSEL = 10'h010, PDAT = 10'h011;

  always #5 clk = ~clk;

  memctl_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .port_num(port_num), .wdata(wdata), .err_set_a(err_set_a),
    .err_set_b(err_set_b), .rdata(rdata), .rvalid(rvalid),
    .irq(irq), .mem_enable(mem_enable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] p, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; port_num = p; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] p, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; port_num = p;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    checks++;
    if (rvalid !== 1'b1) begin
      fails++;
      $display("FAIL R2: rvalid got %0b expected 1", rvalid);
    end
  endtask

  task automatic wreg(input logic [31:0] ofs, input logic [31:0] d);
    wr(PSEL, ofs);
    wr(PDAT, d);
  endtask

  task automatic rreg(input logic [31:0] ofs, output logic [31:0] d);
    wr(PSEL, ofs);
    rd(PDAT, d);
  endtask

  task automatic t_reset;
    chk("R3 irq", {31'b0, irq}, 32'd0);
    chk("R3 enable", {31'b0, mem_enable}, 32'd0);
    rd(PSEL, got);                chk("R3 offset", got, 32'h0);
    rreg(32'h20, got);            chk("R3 config", got, 32'h0080_0000);
    rreg(32'h30, got);            chk("R3 refresh", got, 32'h05F0_0000);
    rreg(32'h34, got);            chk("R3 pwrmgt", got, 32'h07C0_0000);
    rreg(32'h24, got);            chk("R3 status", got, 32'h0);
    rreg(32'h98, got);            chk("R3 eccerr", got, 32'h0);
    rreg(32'h44, got);            chk("R3 bank1", got, 32'h0);
  endtask

  task automatic t_select_and_bus;
    wr(PSEL, 32'h1234_ABCD);
    rd(PSEL, got);                chk("R1 offset readback", got, 32'h1234_ABCD);
    @(negedge clk);
    chk("R2 rvalid low when idle", {31'b0, rvalid}, 32'd0);
    chk("R2 rdata held", rdata, 32'h1234_ABCD);
    wr(10'h012, 32'h0000_0020);
    rd(PSEL, got);                chk("R2 other port write ignored", got, 32'h1234_ABCD);
    rd(10'h012, got);             chk("R2 other port reads zero", got, 32'h0);
  endtask

  task automatic t_plain_and_masks;
    wreg(32'h10, 32'hDEAD_BEEF);
    rreg(32'h10, got);            chk("R5 erradr", got, 32'hDEAD_BEEF);
    wreg(32'h30, 32'hFFFF_FFFF);
    rreg(32'h30, got);            chk("R9 refresh mask", got, 32'h3FF8_0000);
    wreg(32'h34, 32'h0000_0000);
    rreg(32'h34, got);            chk("R9 pwrmgt forced", got, 32'h07C0_0000);
    wreg(32'h34, 32'hFFFF_FFFF);
    rreg(32'h34, got);            chk("R9 pwrmgt ones", got, 32'hFFC0_0000);
    wreg(32'h80, 32'h0000_0000);
    rreg(32'h80, got);            chk("R11 timing reads ones", got, 32'hFFFF_FFFF);
    rreg(32'h04, got);            chk("R11 undefined offset", got, 32'hFFFF_FFFF);
    wreg(32'h94, 32'hFFFF_FFFF);
    rreg(32'h94, got);            chk("R12 ecccfg mask", got, 32'h00F0_0000);
  endtask

  task automatic t_banks;
    for (int b = 0; b < 4; b++)
      wreg(32'h40 + 32'(4 * b), 32'h1111_1111 * 32'(b + 1) | 32'h0000_0001);
    for (int b = 0; b < 4; b++) begin
      rreg(32'h40 + 32'(4 * b), got);
      chk("R10 bank word", got, (32'h1111_1111 * 32'(b + 1) | 32'h0000_0001) & 32'hFFDE_E001);
    end
    wreg(32'h4C, 32'hFFFF_FFFF);
    rreg(32'h4C, got);            chk("R10 bank mask", got, 32'hFFDE_E001);
  endtask

  task automatic t_config;
    wreg(32'h20, 32'hFFFF_FFFF);
    rreg(32'h20, got);            chk("R6 config mask", got, 32'hFFE0_0000);
    chk("R7 enable on", {31'b0, mem_enable}, 32'd1);
    rreg(32'h24, got);            chk("R7 R8 status after rise", got, 32'h4000_0000);
    wreg(32'h24, 32'hFFFF_FFFF);
    rreg(32'h24, got);            chk("R8 status ignores write", got, 32'h4000_0000);
    wreg(32'h20, 32'h0000_0000);
    chk("R7 enable off", {31'b0, mem_enable}, 32'd0);
    rreg(32'h24, got);            chk("R7 R8 status after fall", got, 32'h8000_0000);
    wreg(32'h20, 32'h4000_0000);
    rreg(32'h24, got);            chk("R8 aux rise only", got, 32'hC000_0000);
  endtask

  task automatic t_ecc_irq;
    wreg(32'h98, 32'h0000_0F00);
    rreg(32'h98, got);            chk("R12 eccerr masked to zero", got, 32'h0);
    chk("R13 irq stays low", {31'b0, irq}, 32'd0);
    wreg(32'h98, 32'hFFFF_FFFF);
    rreg(32'h98, got);            chk("R12 eccerr mask", got, 32'hFFF0_F000);
    chk("R13 irq raised", {31'b0, irq}, 32'd1);
    wreg(32'h98, 32'h0000_0000);
    chk("R13 irq cleared", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_error_status;
    @(negedge clk); err_set_a = 32'h0000_00F0; err_set_b = 32'h0000_0005;
    @(negedge clk); err_set_a = '0; err_set_b = '0;
    rreg(32'h00, got);            chk("R4 set a", got, 32'h0000_00F0);
    rreg(32'h08, got);            chk("R4 set b", got, 32'h0000_0005);
    wreg(32'h00, 32'h0000_0030);
    rreg(32'h00, got);            chk("R4 one clears", got, 32'h0000_00C0);
    wr(PSEL, 32'h08);
    @(negedge clk);
    wr_en = 1'b1; port_num = PDAT; wdata = 32'h0000_0005; err_set_b = 32'h0000_0001;
    @(negedge clk);
    wr_en = 1'b0; err_set_b = '0;
    rd(PDAT, got);                chk("R4 set wins", got, 32'h0000_0001);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select_and_bus();
    t_plain_and_masks();
    t_banks();
    t_config();
    t_ecc_irq();
    t_error_status();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule